// File: doc/BRIEF.md
# SECDED Protected Simple Dual-Port Memory

This block is a 512-word memory with one write port and one independent read port. Every word written is widened into a 72-bit codeword: 64 data bits plus eight check bits from an extended Hamming code. The codeword is stored whole. On each read the stored codeword is checked again. A single flipped bit is corrected in the data presented at the read port, and a pair of flipped bits is reported as uncorrectable. Two status flags describe the outcome of the read. A correction is never written back to the array, so a damaged word keeps reporting its error until it is rewritten.

The user data width is a parameter of at most 64 bits. A narrower word is zero-extended before encoding. Both ports use the same width and each write replaces the full word. The read port returns data one clock after the read enable, and when a read and a write hit the same address in one cycle the read returns the contents from before the write. Two write-side inputs let a test deliberately damage the codeword being stored.

Top module: `secded_sdp_ram`

## Requirements
- R1: A word written without injection and later read returns the same data with both flags low. The data and flags change one clock edge after the edge that samples rd_en high.
- R2: A word written with inject_single high (codeword bit 0, the overall parity bit, inverted) reads back with its original data, err_single high and err_double low.
- R3: err_single and err_double are never high together. The encoding is: both low means no error, err_single alone means a corrected single error, and err_double alone means an uncorrectable double error.
- R4: A word written with inject_double high (codeword bits 0 and 1 inverted) reads back with err_double high and err_single low. When both inject inputs are high, inject_double takes precedence.
- R5: A corrected single error is not repaired in storage, so a second read of the same word reports err_single again.
- R6: A read and a write to the same address in the same cycle return the word stored before that write. The new word is visible to later reads.
- R7: While rd_en is low, rd_data, err_single and err_double keep the values from the last completed read.
- R8: The inject inputs have no effect in a cycle where wr_en is low, so a stored word stays clean.
- R9: After reset, rd_data reads zero and both flags are low until the first read.
- R10: A second write to an address replaces the whole stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset of the read-side registers |
| wr_en | input | 1 | Write enable |
| wr_addr | input | ADDR_W (9) | Write address |
| wr_data | input | DATA_W (64) | Write data |
| inject_single | input | 1 | Invert codeword bit 0 of this write |
| inject_double | input | 1 | Invert codeword bits 0 and 1 of this write |
| rd_en | input | 1 | Read enable |
| rd_addr | input | ADDR_W (9) | Read address |
| rd_data | output | DATA_W (64) | Corrected read data |
| err_single | output | 1 | Last read had a corrected single error |
| err_double | output | 1 | Last read had an uncorrectable double error |

## Verification
The hardest condition to create from the ports is a damaged codeword in storage, because the array only holds what the encoder produces. The stimulus therefore relies on the two inject inputs, which place single or double damage on chosen addresses. It then rereads those words to show that the damage persists. It also lines up a damaging write with a same-cycle read of the same address, to show that the read-first result is clean while the next read reports the damage.

// File: rtl/secded_pkg.sv
`timescale 1ns/1ps
package secded_pkg;
  localparam int BASE_W = 64;
  localparam int HAM_W  = 7;
  localparam int CW_W   = BASE_W + HAM_W + 1;

  function automatic logic is_pow2(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  function automatic logic [CW_W-1:0] place_data(input logic [BASE_W-1:0] d);
    logic [CW_W-1:0] cw;
    int k;
    cw = '0;
    k  = 0;
    for (int p = 1; p < CW_W; p++) begin
      if (!is_pow2(p)) begin
        cw[p] = d[k];
        k++;
      end
    end
    return cw;
  endfunction

  function automatic logic [BASE_W-1:0] pull_data(input logic [CW_W-1:0] cw);
    logic [BASE_W-1:0] d;
    int k;
    d = '0;
    k = 0;
    for (int p = 1; p < CW_W; p++) begin
      if (!is_pow2(p)) begin
        d[k] = cw[p];
        k++;
      end
    end
    return d;
  endfunction

  function automatic logic [HAM_W-1:0] syndrome(input logic [CW_W-1:0] cw);
    logic [HAM_W-1:0] s;
    s = '0;
    for (int j = 0; j < HAM_W; j++) begin
      for (int p = 1; p < CW_W; p++) begin
        if (((p >> j) & 1) == 1) s[j] = s[j] ^ cw[p];
      end
    end
    return s;
  endfunction
endpackage

// File: rtl/secded_enc.sv
`timescale 1ns/1ps
module secded_enc
  import secded_pkg::*;
(
  input  logic [BASE_W-1:0] data_in,
  input  logic              inj_one,
  input  logic              inj_two,
  output logic [CW_W-1:0]   cw_out
);
  logic [CW_W-1:0]  body;
  logic [HAM_W-1:0] chk;
  logic [CW_W-1:0]  clean;
  logic [CW_W-1:0]  flip;

  always_comb begin
    body  = place_data(data_in);
    chk   = syndrome(body);
    clean = body;
    for (int j = 0; j < HAM_W; j++) clean[1 << j] = chk[j];
    clean[0] = ^clean[CW_W-1:1];
    flip      = '0;
    flip[0]   = inj_one | inj_two;
    flip[1]   = inj_two;
    cw_out    = clean ^ flip;
  end

  // a clean codeword must have even overall parity and zero syndrome (R1)
  always_comb begin
    if (!inj_one && !inj_two)
      assert_clean_codeword_R1: assert ((^cw_out) == 1'b0 && syndrome(cw_out) == '0);
  end
endmodule

// File: rtl/secded_array.sv
`timescale 1ns/1ps
module secded_array
  import secded_pkg::*;
#(
  parameter int DEPTH  = 512,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [CW_W-1:0]   wcw,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [CW_W-1:0]   rcw
);
  logic [CW_W-1:0] store [DEPTH];
  logic [CW_W-1:0] rcw_d;
  logic [CW_W-1:0] rcw_q;

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wcw;
  end

  always_comb begin
    rcw_d = rcw_q;
    if (re) rcw_d = store[raddr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rcw_q <= '0;
    else        rcw_q <= rcw_d;
  end

  assign rcw = rcw_q;

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> $stable(rcw_q));
endmodule

// File: rtl/secded_dec.sv
`timescale 1ns/1ps
module secded_dec
  import secded_pkg::*;
(
  input  logic [CW_W-1:0]   cw_in,
  output logic [BASE_W-1:0] data_out,
  output logic              one_err,
  output logic              two_err
);
  logic [HAM_W-1:0] syn;
  logic             odd;
  logic [CW_W-1:0]  fixed;

  always_comb begin
    syn     = syndrome(cw_in);
    odd     = ^cw_in;
    fixed   = cw_in;
    one_err = 1'b0;
    two_err = 1'b0;
    if (odd) begin
      if (int'(syn) < CW_W) begin
        fixed[int'(syn)] = ~cw_in[int'(syn)];
        one_err = 1'b1;
      end else begin
        two_err = 1'b1;
      end
    end else if (syn != '0) begin
      two_err = 1'b1;
    end
    data_out = pull_data(fixed);
  end

  always_comb begin
    assert_flag_exclusive_R3: assert (!(one_err && two_err));
  end
endmodule

// File: rtl/secded_sdp_ram.sv
`timescale 1ns/1ps
module secded_sdp_ram
  import secded_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 512,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              inject_single,
  input  logic              inject_double,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              err_single,
  output logic              err_double
);
  logic [BASE_W-1:0] wide_wr;
  logic [BASE_W-1:0] wide_rd;
  logic [CW_W-1:0]   enc_cw;
  logic [CW_W-1:0]   rd_cw;
  logic              inj_one_g;
  logic              inj_two_g;

  generate
    if (DATA_W == BASE_W) begin : g_full
      assign wide_wr = wr_data;
    end else begin : g_pad
      assign wide_wr = {{(BASE_W-DATA_W){1'b0}}, wr_data};
    end
  endgenerate

  assign inj_one_g = wr_en & inject_single;
  assign inj_two_g = wr_en & inject_double;

  secded_enc u_enc (
    .data_in (wide_wr),
    .inj_one (inj_one_g),
    .inj_two (inj_two_g),
    .cw_out  (enc_cw)
  );

  secded_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_array (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .waddr (wr_addr),
    .wcw   (enc_cw),
    .re    (rd_en),
    .raddr (rd_addr),
    .rcw   (rd_cw)
  );

  secded_dec u_dec (
    .cw_in    (rd_cw),
    .data_out (wide_rd),
    .one_err  (err_single),
    .two_err  (err_double)
  );

  assign rd_data = wide_rd[DATA_W-1:0];

  // cycles since reset, saturating, so checks using $past depth 2 stay in range
  logic [1:0] age_d, age_q;
  always_comb age_d = (age_q == 2'd3) ? age_q : age_q + 2'd1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else        age_q <= age_d;
  end

  assert_roundtrip_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2 && $past(rd_en) && $past(wr_en, 2) &&
     !$past(inject_single, 2) && !$past(inject_double, 2) &&
     $past(rd_addr) == $past(wr_addr, 2) &&
     !($past(wr_en) && $past(wr_addr) == $past(rd_addr)))
    |-> (!err_single && !err_double && rd_data == $past(wr_data, 2)));

  assert_single_fix_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2 && $past(rd_en) && $past(wr_en, 2) &&
     $past(inject_single, 2) && !$past(inject_double, 2) &&
     $past(rd_addr) == $past(wr_addr, 2) &&
     !($past(wr_en) && $past(wr_addr) == $past(rd_addr)))
    |-> (err_single && !err_double && rd_data == $past(wr_data, 2)));

  assert_double_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2 && $past(rd_en) && $past(wr_en, 2) && $past(inject_double, 2) &&
     $past(rd_addr) == $past(wr_addr, 2) &&
     !($past(wr_en) && $past(wr_addr) == $past(rd_addr)))
    |-> (err_double && !err_single));

  assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> ($stable(rd_data) && $stable(err_single) && $stable(err_double)));
endmodule

// File: tb/secded_sdp_ram_bench.sv
`timescale 1ns/1ps
module secded_sdp_ram_bench;
  localparam int DW = 64;
  localparam int AW = 9;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, inject_single, inject_double, rd_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data, rd_data;
  logic          err_single, err_double;

  always #2.5 clk = ~clk;

  secded_sdp_ram u_secded_sdp_ram (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .inject_single(inject_single), .inject_double(inject_double),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .err_single(err_single), .err_double(err_double));

  typedef struct {
    logic [DW-1:0] data;
    logic          sb;
    logic          db;
    string         tag;
  } exp_t;

  exp_t          q[$];
  logic [DW-1:0] m_data [1 << AW];
  int            m_stat [1 << AW];
  int            n_cmp = 0;
  int            n_bad = 0;
  logic          issued = 1'b0;
  bit            done = 0;

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expected read result pushed to scoreboard
  task automatic op(input logic we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                    input logic is, input logic id, input logic re,
                    input logic [AW-1:0] ra, input string tag);
    exp_t e;
    @(negedge clk);
    if (re) begin
      e.data = m_data[ra];
      e.sb   = (m_stat[ra] == 1);
      e.db   = (m_stat[ra] == 2);
      e.tag  = tag;
      q.push_back(e);
    end
    if (we) begin
      m_data[wa] = wd;
      m_stat[wa] = id ? 2 : (is ? 1 : 0);
    end
    wr_en = we; wr_addr = wa; wr_data = wd;
    inject_single = is; inject_double = id;
    rd_en = re; rd_addr = ra;
    @(posedge clk);
    #1;
    wr_en = 1'b0; rd_en = 1'b0; inject_single = 1'b0; inject_double = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                    input logic is, input logic id);
    op(1'b1, a, d, is, id, 1'b0, '0, "");
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    op(1'b0, '0, '0, 1'b0, 1'b0, 1'b1, a, tag);
  endtask

  always @(posedge clk) issued <= rd_en & rst_n;

  // monitor: pop and compare one cycle after each read
  always @(negedge clk) begin
    if (issued && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(err_single == e.sb, {e.tag, " err_single"}, DW'(err_single), DW'(e.sb));
      check(err_double == e.db, {e.tag, " err_double"}, DW'(err_double), DW'(e.db));
      check(!(err_single && err_double), "R3 flags exclusive",
            DW'({err_single, err_double}), '0);
      if (!e.db) check(rd_data == e.data, {e.tag, " data"}, rd_data, e.data);
    end
  end

  initial begin
    #100000;
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) begin m_data[i] = '0; m_stat[i] = 0; end
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; inject_single = 1'b0; inject_double = 1'b0;
    wr_addr = '0; rd_addr = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    #1.2 rst_n = 1'b1;
    @(negedge clk);
    check(rd_data == '0, "R9 reset data", rd_data, '0);
    check(err_single == 1'b0, "R9 reset err_single", DW'(err_single), '0);
    check(err_double == 1'b0, "R9 reset err_double", DW'(err_double), '0);

    // R1: several clean patterns
    wr(9'd0, 64'h0, 0, 0);
    wr(9'd1, '1, 0, 0);
    wr(9'd2, 64'hA5A5_5A5A_0123_4567, 0, 0);
    wr(9'd3, 64'h8000_0000_0000_0001, 0, 0);
    wr(9'd511, 64'hDEAD_BEEF_CAFE_F00D, 0, 0);
    rd(9'd0, "R1 zero");
    rd(9'd1, "R1 ones");
    rd(9'd2, "R1 mixed");
    rd(9'd3, "R1 edges");
    rd(9'd511, "R1 top addr");

    // R10: overwrite
    wr(9'd4, 64'h1111_2222_3333_4444, 0, 0);
    wr(9'd4, 64'h5555_6666_7777_8888, 0, 0);
    rd(9'd4, "R10 overwrite");

    // R2, R5: single injection, read twice
    wr(9'd20, 64'h0F0F_F0F0_1234_ABCD, 1, 0);
    rd(9'd20, "R2 single corrected");
    rd(9'd20, "R5 single persists");

    // R4: double injection, and both injects together
    wr(9'd21, 64'h7777_0000_9999_1111, 0, 1);
    rd(9'd21, "R4 double");
    wr(9'd22, 64'h3C3C_3C3C_3C3C_3C3C, 1, 1);
    rd(9'd22, "R4 both injects");

    // R8: inject pulses with wr_en low
    wr(9'd23, 64'h2468_ACE0_1357_9BDF, 0, 0);
    op(1'b0, 9'd23, 64'hFFFF, 1'b1, 1'b0, 1'b0, '0, "");
    op(1'b0, 9'd23, 64'hFFFF, 1'b0, 1'b1, 1'b0, '0, "");
    rd(9'd23, "R8 inject ignored");

    // R6: read-first on same address, new word carries a single error
    wr(9'd30, 64'hAAAA_BBBB_CCCC_DDDD, 0, 0);
    op(1'b1, 9'd30, 64'h0102_0304_0506_0708, 1'b1, 1'b0, 1'b1, 9'd30, "R6 read-first old");
    rd(9'd30, "R6 new word");

    // R7: hold with rd_en low
    repeat (3) @(negedge clk);
    check(rd_data == 64'h0102_0304_0506_0708, "R7 hold data", rd_data,
          64'h0102_0304_0506_0708);
    check(err_single == 1'b1, "R7 hold err_single", DW'(err_single), DW'(1));
    check(err_double == 1'b0, "R7 hold err_double", DW'(err_double), '0);

    repeat (3) @(negedge clk);
    check(q.size() == 0, "R1 scoreboard drained", DW'(q.size()), '0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule